// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block holds two timers, each made of a low byte and a high byte that a processor can read and write. A 2-bit mode per timer sets how the two bytes work together. The modes are:

- a 13-bit count in which the low five bits of the low byte act as a divide-by-32 prescaler for the high byte;
- a plain 16-bit up-counter;
- an 8-bit counter whose low byte reloads from the high byte each time it wraps;
- a split mode.

In split mode, timer 0's low byte counts under timer 0's own controls. Timer 0's high byte counts system ticks under timer 1's run bit and raises timer 1's flag. Timer 1 stands still for as long as timer 0 stays in split mode.

Each timer counts either system ticks (timer function) or falling edges on its own external pin (counter function). The external pin is synchronized before an edge is detected. A gate option adds one more condition: the timer counts only while its gate pin is high. Each timer has one overflow flag. Hardware sets it. An acknowledge strobe from the interrupt logic clears it, and a software write can load it directly.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset, all four count bytes read 00h and both overflow flags are 0.
- R2: A timer whose run bit is 0 keeps its count unchanged.
- R3: Mode 1 joins the high and low bytes into a 16-bit up-counter. A count from FFFFh gives 0000h and sets the timer's flag.
- R4: In mode 0, bits 4:0 of the low byte count input events. Each time those bits wrap from 1Fh, the high byte advances by one, so it moves once every 32 events. Bits 7:5 of the low byte keep their value. A high byte wrapping from FFh sets the flag.
- R5: In mode 2, the low byte counts. A count at FFh loads the low byte from the high byte and sets the flag. The high byte keeps its value.
- R6: With timer 0 in mode 3, timer 0's low byte counts as an 8-bit counter under timer 0's run, gate and function settings. Its wrap from FFh sets flag 0.
- R7: With timer 0 in mode 3, timer 0's high byte counts system ticks while timer 1's run bit is 1. Its wrap from FFh sets flag 1. Timer 1's bytes hold during this time.
- R8: A timer 1 placed in mode 3 holds its count.
- R9: In counter function, the count advances once for each falling edge of the timer's external pin. The pin passes through a two-flop synchronizer, and rising edges do not count.
- R10: With the gate bit at 1, a timer counts only while its synchronized gate pin is high.
- R11: An acknowledge strobe clears a flag, and a software flag write loads the written bit. A hardware overflow in the same cycle wins, and the flag ends at 1.
- R12: A register write takes effect over a count in the same cycle. The write address selects 0 = timer 0 low, 1 = timer 0 high, 2 = timer 1 low, 3 = timer 1 high. The read address uses the same encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | System tick, the count event in timer function |
| ext_pin_i | input | 2 | External count pin per timer |
| gate_pin_i | input | 2 | External gate pin per timer |
| run_i | input | 2 | Run bit per timer |
| gate_en_i | input | 2 | Gate enable per timer |
| cnt_sel_i | input | 2 | 1 = count external pin edges, 0 = count ticks |
| mode0_i | input | 2 | Mode of timer 0 |
| mode1_i | input | 2 | Mode of timer 1 |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | 2 | Byte write address |
| wr_data_i | input | 8 | Byte write data |
| rd_addr_i | input | 2 | Byte read address |
| rd_data_o | output | 8 | Selected byte, combinational |
| flag_ack_i | input | 2 | Interrupt acknowledge, clears a flag |
| flag_wr_i | input | 2 | Software flag write strobe |
| flag_wdat_i | input | 2 | Software flag write value |
| ovf_flag_o | output | 2 | Overflow flags |

## Verification
A table of preloads is run through each counting mode for a fixed number of tick cycles. The preloads sit well below a wrap, exactly at a wrap, and a few counts past one. The results tell a carry into the high byte apart from a reload and from a prescaler rollover, and show whether bits 7:5 of the low byte in mode 0 are left alone.

Directed runs then check the split mode in two phases: timer 0's own controls first, then timer 1's run bit alone. These phases show which byte each run bit drives and which flag each byte raises. Further runs cover edge counting on a pin, including rising edges that must not count, gating held low and then high, and a flag clear or write that coincides with an overflow.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic [1:0] {
    M_PRESC  = 2'd0,
    M_WIDE   = 2'd1,
    M_RELOAD = 2'd2,
    M_SPLIT  = 2'd3
  } tmode_e;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PRE_W  = 5;
  localparam int unsigned N_TMR  = 2;
endpackage

// File: rtl/dmt_pin_sync.sv
module dmt_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic lvl_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q, sh_n;
  logic              prev_q;

  always_comb begin
    sh_n = {sh_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_n;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign fall_o = prev_q & ~sh_q[STAGES-1];

  // R9: one falling edge gives a single-cycle event
  p_fall_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/dmt_unit.sv
module dmt_unit
  import dmt_pkg::*;
#(
  parameter int unsigned W         = BYTE_W,
  parameter int unsigned PW        = PRE_W,
  parameter bit          SPLIT_CAP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tmode_e       mode_i,
  input  logic         en_main_i,
  input  logic         en_hi_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_main_o,
  output logic         ovf_hi_o
);
  logic [W-1:0]  lo_q, lo_n, hi_q, hi_n;
  logic [PW-1:0] pre_n;
  logic          ovf_main, ovf_hi;

  always_comb begin
    lo_n     = lo_q;
    hi_n     = hi_q;
    pre_n    = lo_q[PW-1:0];
    ovf_main = 1'b0;
    ovf_hi   = 1'b0;
    unique case (mode_i)
      M_PRESC: if (en_main_i) begin
        pre_n          = lo_q[PW-1:0] + 1'b1;
        lo_n[PW-1:0]   = pre_n;
        if (&lo_q[PW-1:0]) begin
          hi_n     = hi_q + 1'b1;
          ovf_main = &hi_q;
        end
      end
      M_WIDE: if (en_main_i) begin
        {hi_n, lo_n} = {hi_q, lo_q} + 1'b1;
        ovf_main     = &{hi_q, lo_q};
      end
      M_RELOAD: if (en_main_i) begin
        if (&lo_q) begin
          lo_n     = hi_q;
          ovf_main = 1'b1;
        end else begin
          lo_n = lo_q + 1'b1;
        end
      end
      M_SPLIT: if (SPLIT_CAP) begin
        if (en_main_i) begin
          lo_n     = lo_q + 1'b1;
          ovf_main = &lo_q;
        end
        if (en_hi_i) begin
          hi_n   = hi_q + 1'b1;
          ovf_hi = &hi_q;
        end
      end
      default: ;
    endcase
    if (wr_lo_i) lo_n = wr_data_i;
    if (wr_hi_i) hi_n = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      lo_q <= lo_n;
      hi_q <= hi_n;
    end
  end

  assign lo_o       = lo_q;
  assign hi_o       = hi_q;
  assign ovf_main_o = ovf_main;
  assign ovf_hi_o   = ovf_hi;

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_main_i && !en_hi_i && !wr_lo_i && !wr_hi_i) |=> ($stable(lo_q) && $stable(hi_q)));

  p_wide_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_WIDE && en_main_i && lo_q == '1 && hi_q == '1 && !wr_lo_i && !wr_hi_i)
      |=> (lo_q == '0 && hi_q == '0));

  p_reload_keeps_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_RELOAD && en_main_i && lo_q == '1 && !wr_lo_i && !wr_hi_i)
      |=> ($stable(hi_q) && lo_q == hi_q));

  p_presc_upper_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_PRESC && !wr_lo_i) |=> $stable(lo_q[W-1:PW]));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        ext_pin_i,
  input  logic [1:0]        gate_pin_i,
  input  logic [1:0]        run_i,
  input  logic [1:0]        gate_en_i,
  input  logic [1:0]        cnt_sel_i,
  input  logic [1:0]        mode0_i,
  input  logic [1:0]        mode1_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic [1:0]        flag_ack_i,
  input  logic [1:0]        flag_wr_i,
  input  logic [1:0]        flag_wdat_i,
  output logic [1:0]        ovf_flag_o
);
  localparam int unsigned NT = N_TMR;

  logic [NT-1:0] gate_lvl, ext_fall, cnt_en;
  logic [NT-1:0] flag_q, flag_n, flag_set;
  logic [BYTE_W-1:0] lo0, hi0, lo1, hi1;
  logic ovf0_main, ovf0_hi, ovf1_main, ovf1_hi;
  logic split;
  tmode_e md0, md1;

  for (genvar g = 0; g < NT; g++) begin : g_pin
    dmt_pin_sync #(.STAGES(2)) u_ext (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[g]),
      .lvl_o(), .fall_o(ext_fall[g]));
    logic gate_fall_unused;
    dmt_pin_sync #(.STAGES(2)) u_gate (
      .clk(clk), .rst_n(rst_n), .pin_i(gate_pin_i[g]),
      .lvl_o(gate_lvl[g]), .fall_o(gate_fall_unused));
    assign cnt_en[g] = run_i[g] & (~gate_en_i[g] | gate_lvl[g]) &
                       (cnt_sel_i[g] ? ext_fall[g] : tick_i);
  end

  assign md0   = tmode_e'(mode0_i);
  assign md1   = tmode_e'(mode1_i);
  assign split = (md0 == M_SPLIT);

  dmt_unit #(.W(BYTE_W), .PW(PRE_W), .SPLIT_CAP(1'b1)) u_t0 (
    .clk(clk), .rst_n(rst_n), .mode_i(md0),
    .en_main_i(cnt_en[0]), .en_hi_i(run_i[1] & tick_i),
    .wr_lo_i(wr_en_i && wr_addr_i == 2'd0), .wr_hi_i(wr_en_i && wr_addr_i == 2'd1),
    .wr_data_i(wr_data_i), .lo_o(lo0), .hi_o(hi0),
    .ovf_main_o(ovf0_main), .ovf_hi_o(ovf0_hi));

  dmt_unit #(.W(BYTE_W), .PW(PRE_W), .SPLIT_CAP(1'b0)) u_t1 (
    .clk(clk), .rst_n(rst_n), .mode_i(md1),
    .en_main_i(cnt_en[1] & ~split), .en_hi_i(1'b0),
    .wr_lo_i(wr_en_i && wr_addr_i == 2'd2), .wr_hi_i(wr_en_i && wr_addr_i == 2'd3),
    .wr_data_i(wr_data_i), .lo_o(lo1), .hi_o(hi1),
    .ovf_main_o(ovf1_main), .ovf_hi_o(ovf1_hi));

  assign flag_set[0] = ovf0_main;
  assign flag_set[1] = split ? ovf0_hi : (ovf1_main | ovf1_hi);

  always_comb begin
    for (int i = 0; i < NT; i++) begin
      flag_n[i] = flag_q[i];
      if (flag_ack_i[i]) flag_n[i] = 1'b0;
      if (flag_wr_i[i])  flag_n[i] = flag_wdat_i[i];
      if (flag_set[i])   flag_n[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_n;
  end

  always_comb begin
    unique case (rd_addr_i)
      2'd0:    rd_data_o = lo0;
      2'd1:    rd_data_o = hi0;
      2'd2:    rd_data_o = lo1;
      default: rd_data_o = hi1;
    endcase
  end

  assign ovf_flag_o = flag_q;

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|flag_set) |=> ((ovf_flag_o & $past(flag_set)) == $past(flag_set)));

  p_t1_halt_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !(wr_en_i && wr_addr_i[1])) |=> ($stable(lo1) && $stable(hi1)));

  p_t1_mode3_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md1 == M_SPLIT && !(wr_en_i && wr_addr_i[1])) |=> ($stable(lo1) && $stable(hi1)));
endmodule

// File: tb/dual_mode_timer_test.sv
`timescale 1ns/1ps
module dual_mode_timer_test;
  logic clk = 1'b0;
  logic rst_n;
  logic tick_i;
  logic [1:0] ext_pin_i, gate_pin_i, run_i, gate_en_i, cnt_sel_i, mode0_i, mode1_i;
  logic wr_en_i;
  logic [1:0] wr_addr_i, rd_addr_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic [1:0] flag_ack_i, flag_wr_i, flag_wdat_i, ovf_flag_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_mode_timer uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_pin_i(ext_pin_i),
    .gate_pin_i(gate_pin_i), .run_i(run_i), .gate_en_i(gate_en_i),
    .cnt_sel_i(cnt_sel_i), .mode0_i(mode0_i), .mode1_i(mode1_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .flag_ack_i(flag_ack_i),
    .flag_wr_i(flag_wr_i), .flag_wdat_i(flag_wdat_i), .ovf_flag_o(ovf_flag_o));

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] tl;
    logic [7:0] th;
    logic [7:0] n;
    logic [7:0] etl;
    logic [7:0] eth;
    logic       ef;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd1, 8'h00, 8'h00, 8'd5,  8'h05, 8'h00, 1'b0},  // R3 plain
    '{2'd1, 8'hFE, 8'h00, 8'd3,  8'h01, 8'h01, 1'b0},  // R3 carry
    '{2'd1, 8'hFF, 8'hFF, 8'd1,  8'h00, 8'h00, 1'b1},  // R3 wrap
    '{2'd1, 8'hFD, 8'hFF, 8'd5,  8'h02, 8'h00, 1'b1},  // R3 past wrap
    '{2'd0, 8'h1F, 8'h00, 8'd1,  8'h00, 8'h01, 1'b0},  // R4 prescale carry
    '{2'd0, 8'h1E, 8'hFF, 8'd3,  8'h01, 8'h00, 1'b1},  // R4 overflow
    '{2'd0, 8'hE0, 8'h05, 8'd32, 8'hE0, 8'h06, 1'b0},  // R4 div 32, upper bits kept
    '{2'd2, 8'hFE, 8'h80, 8'd3,  8'h81, 8'h80, 1'b1},  // R5 reload
    '{2'd2, 8'h10, 8'hAA, 8'd4,  8'h14, 8'hAA, 1'b0}   // R5 no reload
  };

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    #0.5;
    d = rd_data_o;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic run_n(input logic [1:0] m, input int n);
    @(negedge clk);
    run_i = m;
    repeat (n) @(negedge clk);
    run_i = 2'b00;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    flag_ack_i = 2'b11;
    @(negedge clk);
    flag_ack_i = 2'b00;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; tick_i = 1'b1; ext_pin_i = '0; gate_pin_i = '0; run_i = '0;
    gate_en_i = '0; cnt_sel_i = '0; mode0_i = 2'd1; mode1_i = 2'd1;
    wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    flag_ack_i = '0; flag_wr_i = '0; flag_wdat_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); chk("R1 byte", d, 8'h00);
    end
    chk("R1 flags", {6'd0, ovf_flag_o}, 8'h00);

    // table walk on timer 0
    for (int i = 0; i < 9; i++) begin
      mode0_i = VEC[i].md;
      wr(2'd0, VEC[i].tl);
      wr(2'd1, VEC[i].th);
      clr_flags();
      run_n(2'b01, int'(VEC[i].n));
      rd(2'd0, d); chk("R3/R4/R5 low", d, VEC[i].etl);
      rd(2'd1, d); chk("R3/R4/R5 high", d, VEC[i].eth);
      chk("R3/R4/R5 flag", {7'd0, ovf_flag_o[0]}, {7'd0, VEC[i].ef});
    end

    // R2 run bit low holds
    mode0_i = 2'd1; wr(2'd0, 8'h42); wr(2'd1, 8'h00);
    repeat (6) @(negedge clk);
    rd(2'd0, d); chk("R2 hold", d, 8'h42);

    // R12 write wins over count
    @(negedge clk);
    run_i = 2'b01; wr_en_i = 1'b1; wr_addr_i = 2'd0; wr_data_i = 8'h50;
    @(negedge clk);
    run_i = 2'b00; wr_en_i = 1'b0;
    rd(2'd0, d); chk("R12 write priority", d, 8'h50);

    // R6/R7 split mode
    clr_flags();
    mode1_i = 2'd1; wr(2'd2, 8'h10);
    mode0_i = 2'd3; wr(2'd0, 8'hFE); wr(2'd1, 8'hFE);
    run_n(2'b01, 3);
    rd(2'd0, d); chk("R6 low byte", d, 8'h01);
    rd(2'd1, d); chk("R6 high untouched", d, 8'hFE);
    chk("R6 flags", {6'd0, ovf_flag_o}, 8'h01);
    run_n(2'b10, 3);
    rd(2'd1, d); chk("R7 high byte", d, 8'h01);
    rd(2'd0, d); chk("R7 low held", d, 8'h01);
    chk("R7 flag1", {6'd0, ovf_flag_o}, 8'h03);
    rd(2'd2, d); chk("R7 timer1 halted", d, 8'h10);

    // R11 flag clear and write
    @(negedge clk); flag_ack_i = 2'b01;
    @(negedge clk); flag_ack_i = 2'b00;
    chk("R11 ack clears", {6'd0, ovf_flag_o}, 8'h02);
    @(negedge clk); flag_wr_i = 2'b11; flag_wdat_i = 2'b01;
    @(negedge clk); flag_wr_i = 2'b00;
    chk("R11 sw write", {6'd0, ovf_flag_o}, 8'h01);
    clr_flags();
    mode0_i = 2'd1; wr(2'd0, 8'hFF); wr(2'd1, 8'hFF);
    @(negedge clk); run_i = 2'b01; flag_ack_i = 2'b01;
    @(negedge clk); run_i = 2'b00; flag_ack_i = 2'b00;
    chk("R11 set beats clear", {7'd0, ovf_flag_o[0]}, 8'h01);

    // R8 timer 1 in mode 3 holds
    clr_flags();
    mode1_i = 2'd3; wr(2'd2, 8'h33);
    run_n(2'b10, 4);
    rd(2'd2, d); chk("R8 hold", d, 8'h33);
    chk("R8 no flag", {6'd0, ovf_flag_o}, 8'h00);
    mode1_i = 2'd1;

    // R10 gate
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    gate_en_i = 2'b01; gate_pin_i = 2'b00;
    run_n(2'b01, 5);
    rd(2'd0, d); chk("R10 gated off", d, 8'h00);
    gate_pin_i = 2'b01;
    repeat (4) @(negedge clk);
    run_n(2'b01, 5);
    rd(2'd0, d); chk("R10 gated on", d, 8'h05);
    gate_en_i = 2'b00; gate_pin_i = 2'b00;

    // R9 external falling edges
    wr(2'd0, 8'h00);
    cnt_sel_i = 2'b01; tick_i = 1'b0;
    @(negedge clk); run_i = 2'b01;
    for (int k = 0; k < 3; k++) begin
      ext_pin_i = 2'b01; repeat (4) @(negedge clk);
      ext_pin_i = 2'b00; repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    run_i = 2'b00;
    rd(2'd0, d); chk("R9 edge count", d, 8'h03);
    cnt_sel_i = 2'b00; tick_i = 1'b1;

    done = 1'b1;
    summary();
    $finish;
  end
endmodule